// File: doc/BRIEF.md
# Core Interrupt and Control Pin Front End

This block sits between the raw control pins of a processor core and the core's pending-interrupt logic. It watches seven pins: two interrupt requests, a machine-check line, a stop line, a hard-reset line, a soft-reset line and a time-base run line. It turns each pin into the action that pin calls for. Some pins set or clear a pending bit. Others halt the core, request a core reset, or let the time base run or freeze it. Each pin applies its own polarity and its own edge or level rule.

Every pin passes through a two-flop synchroniser. The block keeps a registered copy of the last synchronised level of each pin, and a pin causes an action only in the cycle where its synchronised level differs from that copy. Driving a pin to a level it already holds therefore does nothing. The pending bits form a vector with a summary request output. The core clears any bit with a per-bit clear input. Priority resolution, vectoring and acknowledge are left to the core.

Top module: `core_pin_ctrl`

## Requirements
- R1: A pin causes an action only when its synchronised level differs from the stored copy. A pin change reaches the outputs on the third rising clock edge after it is applied. Holding a pin at an unchanged level never sets a cleared bit again and never repeats a reset request.
- R2: Pending bit 0 follows the external interrupt pin and bit 1 follows the system-management interrupt pin. Both pins are active high: a rising change sets the bit and a falling change clears it.
- R3: Pending bit 2 is set by a 1-to-0 change of the machine-check pin only. A rising change has no effect, and the bit stays set until it is cleared through the clear input.
- R4: A 1-to-0 change of the active-low stop pin sets `halt_o`. The halt stays set when the pin returns high, and it is released only by a block reset or by a hard-reset request.
- R5: A 1-to-0 change of the active-low hard-reset pin makes `core_rst_req_o` high for exactly one cycle.
- R6: Pending bit 3 follows the soft-reset pin, which is active high: a rising change sets the bit and a falling change clears it.
- R7: `tb_run_o` goes to 1 on a rising change of the time-base enable pin and to 0 on a falling change. It is 0 after reset, which means the time base is frozen.
- R8: `irq_req_o` is high exactly when at least one pending bit is set. It drops in the same cycle that the vector becomes all zero.
- R9: Setting bit n of `clr_i` clears pending bit n at the next clock edge. If a set event for the same bit falls on that same edge, the set event wins.
- R10: A block reset clears the synchroniser, the stored level copy, the pending vector, `halt_o`, `tb_run_o` and `core_rst_req_o`. An active-low pin held low through reset therefore causes no action until it has been seen high and then low again.
- R11: When the stop pin and the hard-reset pin fall on the same edge, `core_rst_req_o` still pulses and `halt_o` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| ext_irq_i | input | 1 | External interrupt pin, active high level |
| smi_i | input | 1 | System-management interrupt pin, active high level |
| mchk_i | input | 1 | Machine-check pin, falling-edge sensitive |
| chkstop_n_i | input | 1 | Stop pin, active low |
| hreset_n_i | input | 1 | Hard-reset pin, active low |
| sreset_i | input | 1 | Soft-reset pin, active high level |
| tb_en_i | input | 1 | Time-base enable pin, active high |
| clr_i | input | 4 | Per-bit clear of the pending vector |
| pend_o | output | 4 | Pending vector: bit 0 external, bit 1 system-management, bit 2 machine check, bit 3 soft reset |
| irq_req_o | output | 1 | OR of all pending bits |
| halt_o | output | 1 | Core halt request |
| core_rst_req_o | output | 1 | One-cycle core reset request |
| tb_run_o | output | 1 | Time base run (1) or frozen (0) |

## Verification
Two pairs of actions can land on the same clock edge.

- **Clear and set on the same bit.** The bench raises the system-management pin and asserts `clr_i` for that bit in the exact cycle whose edge turns the synchronised change into an event. It expects the bit to end up set. It also clears the external bit on an edge where the pin is still high but unchanged, and expects the bit to stay clear.
- **Stop and hard reset together.** The bench drops the stop pin and the hard-reset pin in the same cycle. It expects both a reset pulse and a set halt.

// File: rtl/cpin_pkg.sv
package cpin_pkg;

    // pin vector layout
    localparam int unsigned PIN_W  = 7;
    localparam int unsigned P_EXT  = 0;
    localparam int unsigned P_SMI  = 1;
    localparam int unsigned P_MCHK = 2;
    localparam int unsigned P_STOP = 3;
    localparam int unsigned P_HRST = 4;
    localparam int unsigned P_SRST = 5;
    localparam int unsigned P_TBEN = 6;

    // pending vector layout
    localparam int unsigned PEND_W = 4;
    localparam int unsigned B_EXT  = 0;
    localparam int unsigned B_SMI  = 1;
    localparam int unsigned B_MCHK = 2;
    localparam int unsigned B_SRST = 3;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              halt;
        logic              tb_run;
        logic              rst_req;
    } act_state_t;

endpackage

// File: rtl/cpin_sync.sv
module cpin_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cpin_change_det.sv
module cpin_change_det #(
    parameter int unsigned W = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);

    typedef struct packed {
        logic [W-1:0] seen;
    } det_state_t;

    det_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        chg_o    = lvl_i ^ s_q.seen;
        // only differing bits move; equal bits keep their value anyway
        s_d.seen = (s_q.seen & ~chg_o) | (lvl_i & chg_o);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/cpin_action.sv
module cpin_action
    import cpin_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PIN_W-1:0]  lvl_i,
    input  logic [PIN_W-1:0]  chg_i,
    input  logic [PEND_W-1:0] clr_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o,
    output logic              halt_o,
    output logic              tb_run_o,
    output logic              rst_req_o
);

    act_state_t        s_d, s_q;
    logic [PIN_W-1:0]  rise, fall;
    logic [PEND_W-1:0] set_v, drop_v;

    always_comb begin
        rise = chg_i & lvl_i;
        fall = chg_i & ~lvl_i;

        set_v  = '0;
        drop_v = '0;
        set_v[B_EXT]   = rise[P_EXT];
        drop_v[B_EXT]  = fall[P_EXT];
        set_v[B_SMI]   = rise[P_SMI];
        drop_v[B_SMI]  = fall[P_SMI];
        set_v[B_SRST]  = rise[P_SRST];
        drop_v[B_SRST] = fall[P_SRST];
        set_v[B_MCHK]  = fall[P_MCHK];

        s_d         = s_q;
        s_d.rst_req = 1'b0;
        // a set event outranks the clear input on the same edge
        s_d.pend    = (s_q.pend & ~clr_i & ~drop_v) | set_v;

        if (fall[P_HRST]) begin
            s_d.rst_req = 1'b1;
            s_d.halt    = 1'b0;
        end
        if (fall[P_STOP]) begin
            s_d.halt = 1'b1;
        end
        if (rise[P_TBEN]) begin
            s_d.tb_run = 1'b1;
        end else if (fall[P_TBEN]) begin
            s_d.tb_run = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o    = s_q.pend;
    assign irq_o     = |s_q.pend;
    assign halt_o    = s_q.halt;
    assign tb_run_o  = s_q.tb_run;
    assign rst_req_o = s_q.rst_req;

endmodule

// File: rtl/core_pin_ctrl.sv
module core_pin_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        ext_irq_i,
    input  logic                        smi_i,
    input  logic                        mchk_i,
    input  logic                        chkstop_n_i,
    input  logic                        hreset_n_i,
    input  logic                        sreset_i,
    input  logic                        tb_en_i,
    input  logic [cpin_pkg::PEND_W-1:0] clr_i,
    output logic [cpin_pkg::PEND_W-1:0] pend_o,
    output logic                        irq_req_o,
    output logic                        halt_o,
    output logic                        core_rst_req_o,
    output logic                        tb_run_o
);

    import cpin_pkg::*;

    logic [PIN_W-1:0] pins_raw, pins_sync, pins_chg;

    always_comb begin
        pins_raw         = '0;
        pins_raw[P_EXT]  = ext_irq_i;
        pins_raw[P_SMI]  = smi_i;
        pins_raw[P_MCHK] = mchk_i;
        pins_raw[P_STOP] = chkstop_n_i;
        pins_raw[P_HRST] = hreset_n_i;
        pins_raw[P_SRST] = sreset_i;
        pins_raw[P_TBEN] = tb_en_i;
    end

    cpin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pins_raw),
        .q_o    (pins_sync)
    );

    cpin_change_det #(.W(PIN_W)) u_det (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (pins_sync),
        .chg_o  (pins_chg)
    );

    cpin_action u_act (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (pins_sync),
        .chg_i     (pins_chg),
        .clr_i     (clr_i),
        .pend_o    (pend_o),
        .irq_o     (irq_req_o),
        .halt_o    (halt_o),
        .tb_run_o  (tb_run_o),
        .rst_req_o (core_rst_req_o)
    );

endmodule

// File: rtl/core_pin_ctrl_chk.sv
module core_pin_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       ext_irq_i,
    input logic       smi_i,
    input logic       mchk_i,
    input logic       chkstop_n_i,
    input logic       hreset_n_i,
    input logic       sreset_i,
    input logic       tb_en_i,
    input logic [3:0] clr_i,
    input logic [3:0] pend_o,
    input logic       irq_req_o,
    input logic       halt_o,
    input logic       core_rst_req_o,
    input logic       tb_run_o
);

    AST_IRQ_IS_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o == (pend_o != 4'b0000)); // R8

    AST_RST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_req_o |=> !core_rst_req_o); // R5

    AST_HALT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halt_o && $past(halt_o)) |-> core_rst_req_o); // R4

    AST_MCHK_CLEAR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_o[2]) |-> $past(clr_i[2])); // R3

    AST_MCHK_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o[2]) |-> !$past(mchk_i, 2)); // R3

    AST_TB_FROM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tb_run_o) |-> $past(tb_en_i, 2)); // R7

    AST_EXT_FROM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o[0]) |-> $past(ext_irq_i, 2)); // R2

    AST_SRST_FROM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o[3]) |-> $past(sreset_i, 2)); // R6

endmodule

bind core_pin_ctrl core_pin_ctrl_chk u_chk (.*);

// File: tb/core_pin_ctrl_bench.sv
module core_pin_ctrl_bench;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ext_irq_i = 1'b0, smi_i = 1'b0, mchk_i = 1'b0;
    logic       chkstop_n_i = 1'b1, hreset_n_i = 1'b1;
    logic       sreset_i = 1'b0, tb_en_i = 1'b0;
    logic [3:0] clr_i = 4'b0000;
    logic [3:0] pend_o;
    logic       irq_req_o, halt_o, core_rst_req_o, tb_run_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk_i = ~clk_i; // 50 MHz

    core_pin_ctrl u_core_pin_ctrl (.*);

    // pins {tb_en, sreset, hreset_n, chkstop_n, mchk, smi, ext}, clr, pend, {halt, tb_run, rst_req}
    localparam int NV = 21;
    localparam logic [17:0] VECS [NV] = '{
        {7'b0011001, 4'b0000, 4'b0001, 3'b000}, // R2 ext rises
        {7'b0011001, 4'b0001, 4'b0000, 3'b000}, // R1 R9 clear while ext held
        {7'b0011010, 4'b0000, 4'b0010, 3'b000}, // R2 ext falls, smi rises
        {7'b0011000, 4'b0000, 4'b0000, 3'b000}, // R2 smi falls
        {7'b0011100, 4'b0000, 4'b0000, 3'b000}, // R3 mchk rise ignored
        {7'b0011000, 4'b0000, 4'b0100, 3'b000}, // R3 mchk falls
        {7'b0011000, 4'b0100, 4'b0000, 3'b000}, // R3 R9 mchk cleared
        {7'b0111000, 4'b0000, 4'b1000, 3'b000}, // R6 soft reset high
        {7'b0011001, 4'b0000, 4'b0001, 3'b000}, // R6 soft reset low, ext high
        {7'b1011001, 4'b0000, 4'b0001, 3'b010}, // R7 time base runs
        {7'b0011001, 4'b0000, 4'b0001, 3'b000}, // R7 time base frozen
        {7'b0011011, 4'b0010, 4'b0011, 3'b000}, // R9 set beats clear
        {7'b0001011, 4'b0000, 4'b0011, 3'b001}, // R5 hard reset pulse
        {7'b0001011, 4'b0000, 4'b0011, 3'b000}, // R1 R5 held low, no repeat
        {7'b0011011, 4'b0000, 4'b0011, 3'b000}, // R5 release
        {7'b0010011, 4'b0000, 4'b0011, 3'b100}, // R4 stop
        {7'b0011011, 4'b0000, 4'b0011, 3'b100}, // R4 halt sticky
        {7'b0001011, 4'b0000, 4'b0011, 3'b001}, // R4 R5 hard reset releases halt
        {7'b0011011, 4'b0000, 4'b0011, 3'b000}, // R5 release
        {7'b0000011, 4'b0000, 4'b0011, 3'b101}, // R11 stop and hard reset together
        {7'b0000011, 4'b1111, 4'b0000, 3'b100}  // R8 R9 all cleared, request drops
    };

    task automatic check(input string tag, input logic [3:0] ep,
                         input logic eh, input logic et, input logic er);
        n_vec++;
        if (pend_o !== ep || irq_req_o !== (|ep) || halt_o !== eh ||
            tb_run_o !== et || core_rst_req_o !== er) begin
            n_bad++;
            $display("FAIL %s: got pend=%b irq=%b halt=%b tb=%b rq=%b exp pend=%b irq=%b halt=%b tb=%b rq=%b",
                     tag, pend_o, irq_req_o, halt_o, tb_run_o, core_rst_req_o,
                     ep, |ep, eh, et, er);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the third rising edge
    task automatic apply(input logic [6:0] p, input logic [3:0] c);
        {tb_en_i, sreset_i, hreset_n_i, chkstop_n_i, mchk_i, smi_i, ext_irq_i} = p;
        clr_i = 4'b0000;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        clr_i = c;
        @(posedge clk_i);
        @(negedge clk_i);
        clr_i = 4'b0000;
    endtask

    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got cycle=%0d exp done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (4) @(negedge clk_i);
        check("R10 reset state", 4'b0000, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][17:11], VECS[i][10:7]);
            check($sformatf("vec %0d", i), VECS[i][6:3], VECS[i][2], VECS[i][1], VECS[i][0]);
        end

        // R10: reset clears halt; stop held low through reset gives no event
        rst_ni = 1'b0;
        {tb_en_i, sreset_i, hreset_n_i, chkstop_n_i, mchk_i, smi_i, ext_irq_i} = 7'b0010000;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (5) @(negedge clk_i);
        check("R10 stop low through reset", 4'b0000, 1'b0, 1'b0, 1'b0);
        apply(7'b0011000, 4'b0000);
        check("R10 stop seen high", 4'b0000, 1'b0, 1'b0, 1'b0);
        apply(7'b0010000, 4'b0000);
        check("R4 stop after reset", 4'b0000, 1'b1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule